// File: doc/BRIEF.md
# Mailbox Transmit Priority Arbiter

This block decides which of a bank of message mailboxes in a CAN-style controller is handed next to the frame transmitter. A mailbox takes part only when it is enabled, set to the transmit direction and has a raised transmit request. Among those, the mailbox with the largest priority value in its control word wins. When priorities are equal, the higher mailbox number wins. The frame transmitter is modelled by a start/done handshake. While a frame is in flight the choice is frozen. Arbitration runs again only once the transmitter is idle.

Software reaches the block through a write port with four targets: request-set, request-cancel, acknowledge-clear and abort-acknowledge-clear. When a frame completes, the block clears that mailbox's request and sets its acknowledge bit. If the mailbox's interrupt mask bit is set, it also raises a mailbox interrupt flag. The block also decodes the selected mailbox's control word for the transmitter: the payload length (capped at eight bytes), the remote-request flag, and whether the upper data word is needed.

Top module: `mtx_prio_arbiter`

## Requirements
- R1: After reset, the request, acknowledge and abort-acknowledge vectors, `tx_start`, `tx_busy` and `mbx_irq` are all 0.
- R2: A write with `wr_sel`=0 raises the request of every mailbox whose `wr_data` bit is 1. Bits written as 0 leave their requests unchanged.
- R3: A mailbox is eligible only when its `mbx_en` bit is 1, its `mbx_dir` bit is 0 and its request is raised. Non-eligible requests stay pending and are never started.
- R4: The eligible mailbox with the largest priority field wins. The priority field is bits [13:8] of that mailbox's 16-bit control word, and word i sits at `mbx_ctrl[16*i +: 16]`.
- R5: Among eligible mailboxes that share the top priority value, the highest mailbox index wins.
- R6: A launch drives `tx_start` high for exactly one cycle and sets `tx_busy`. While busy, `tx_index` holds, and a new request, even one with higher priority, cannot preempt the frame in flight.
- R7: When `tx_done` is seen while busy, the frame's request is cleared, its `tx_ack` bit is set and `tx_busy` falls. A write with `wr_sel`=2 clears each acknowledge bit written as 1.
- R8: A write with `wr_sel`=1 cancels each pending request written as 1 that is not in flight, and sets the matching `abort_ack` bit. It has no effect on the mailbox in flight or on mailboxes without a pending request. A write with `wr_sel`=3 clears each `abort_ack` bit written as 1.
- R9: A completion raises `mbx_irq` only when that mailbox's `mbx_irq_mask` bit is 1. A `wr_sel`=2 write with any bit set clears `mbx_irq`.
- R10: While busy, the block decodes the selected mailbox's control word for the transmitter. `tx_len` is the length field (bits [3:0]) capped at 8. `tx_rtr` is bit 4. `tx_high_word` is 1 only when the capped length exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 request-set, 1 request-cancel, 2 acknowledge-clear, 3 abort-acknowledge-clear |
| wr_data | input | 32 | One bit per mailbox for the write |
| mbx_en | input | 32 | Mailbox enable bits |
| mbx_dir | input | 32 | Mailbox direction, 0 = transmit |
| mbx_irq_mask | input | 32 | Per-mailbox interrupt mask |
| mbx_ctrl | input | 512 | Control words, 16 bits per mailbox |
| tx_start | output | 1 | One-cycle launch pulse to the transmitter |
| tx_busy | output | 1 | A frame is in flight |
| tx_index | output | 5 | Mailbox being transmitted |
| tx_len | output | 4 | Capped payload length |
| tx_rtr | output | 1 | Remote-request flag of the frame |
| tx_high_word | output | 1 | Upper data word is needed |
| tx_done | input | 1 | Transmitter completion pulse |
| tx_req | output | 32 | Pending request vector |
| tx_ack | output | 32 | Transmit acknowledge vector |
| abort_ack | output | 32 | Abort acknowledge vector |
| mbx_irq | output | 1 | Mailbox interrupt flag |

## Verification
The properties assume that enable, direction and control words do not change while a request for that mailbox is pending or in flight. The bench reconfigures mailboxes only while the transmitter is idle and no request is raised. They also assume that `tx_done` arrives only after a launch and lasts a single cycle. The bench pulses it once per launch, after `tx_busy` has been observed. The write port is driven one write at a time, away from the clock edge. The bench's expected order comes from its own maximum search over the same priority fields.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
    // control word layout (decoded by the transmitter side)
    localparam int CTRL_W   = 16;
    localparam int PRIO_LSB = 8;
    localparam int PRIO_W   = 6;
    localparam int RTR_BIT  = 4;
    localparam int DLC_W    = 4;

    typedef enum logic [1:0] {
        WR_REQ_SET = 2'd0,
        WR_REQ_CLR = 2'd1,
        WR_ACK_CLR = 2'd2,
        WR_ABT_CLR = 2'd3
    } wr_sel_e;
endpackage

// File: rtl/mtx_pick_tree.sv
module mtx_pick_tree #(
    parameter int N_MBX  = 32,
    parameter int PRIO_W = 6
) (
    input  logic [N_MBX-1:0]        elig,
    input  logic [N_MBX*PRIO_W-1:0] prio_flat,
    output logic                    win_valid,
    output logic [$clog2(N_MBX)-1:0] win_idx
);
    localparam int IDX_W = $clog2(N_MBX);
    localparam int LEAVES = 1 << IDX_W;
    localparam int KEY_W = 1 + PRIO_W + IDX_W;

    // key = {valid, priority, index}; a plain max gives priority first, index on ties
    for (genvar l = 0; l <= IDX_W; l++) begin : g_lvl
        localparam int WIDTH = LEAVES >> l;
        logic [KEY_W-1:0] key [WIDTH];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < LEAVES; i++) begin : g_i
                if (i < N_MBX) begin : g_real
                    assign key[i] = elig[i] ?
                        {1'b1, prio_flat[i*PRIO_W +: PRIO_W], IDX_W'(i)} : '0;
                end else begin : g_pad
                    assign key[i] = '0;
                end
            end
        end else begin : g_node
            for (genvar i = 0; i < WIDTH; i++) begin : g_i
                assign key[i] = (g_lvl[l-1].key[2*i+1] > g_lvl[l-1].key[2*i]) ?
                                g_lvl[l-1].key[2*i+1] : g_lvl[l-1].key[2*i];
            end
        end
    end

    logic [KEY_W-1:0] root;
    assign root      = g_lvl[IDX_W].key[0];
    assign win_valid = root[KEY_W-1];
    assign win_idx   = root[IDX_W-1:0];
endmodule

// File: rtl/mtx_frame_fields.sv
module mtx_frame_fields #(
    parameter int DLC_W    = 4,
    parameter int LEN_MAX  = 8,
    parameter int HIGH_THR = 4
) (
    input  logic [DLC_W-1:0] dlc,
    input  logic             rtr_in,
    output logic [DLC_W-1:0] len,
    output logic             rtr,
    output logic             use_high
);
    always_comb begin
        len      = (dlc > DLC_W'(LEN_MAX)) ? DLC_W'(LEN_MAX) : dlc;
        use_high = (len > DLC_W'(HIGH_THR));
        rtr      = rtr_in;
    end
endmodule

// File: rtl/mtx_prio_arbiter.sv
module mtx_prio_arbiter
    import mtx_pkg::*;
#(
    parameter int N_MBX   = 32,
    parameter int LEN_MAX = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_sel,
    input  logic [N_MBX-1:0]          wr_data,
    input  logic [N_MBX-1:0]          mbx_en,
    input  logic [N_MBX-1:0]          mbx_dir,
    input  logic [N_MBX-1:0]          mbx_irq_mask,
    input  logic [N_MBX*CTRL_W-1:0]   mbx_ctrl,
    output logic                      tx_start,
    output logic                      tx_busy,
    output logic [$clog2(N_MBX)-1:0]  tx_index,
    output logic [DLC_W-1:0]          tx_len,
    output logic                      tx_rtr,
    output logic                      tx_high_word,
    input  logic                      tx_done,
    output logic [N_MBX-1:0]          tx_req,
    output logic [N_MBX-1:0]          tx_ack,
    output logic [N_MBX-1:0]          abort_ack,
    output logic                      mbx_irq
);
    localparam int IDX_W = $clog2(N_MBX);

    typedef struct packed {
        logic [N_MBX-1:0] req;
        logic [N_MBX-1:0] ack;
        logic [N_MBX-1:0] abt;
        logic             busy;
        logic             start;
        logic             irq;
        logic [IDX_W-1:0] cur;
    } st_t;

    st_t st_d, st_q;

    // priority fields and reserved-bit sink
    logic [N_MBX*PRIO_W-1:0] prio_flat;
    logic [N_MBX-1:0]        unused_rsvd_bits;
    for (genvar i = 0; i < N_MBX; i++) begin : g_mbx
        assign prio_flat[i*PRIO_W +: PRIO_W] = mbx_ctrl[i*CTRL_W + PRIO_LSB +: PRIO_W];
        assign unused_rsvd_bits[i] = ^{mbx_ctrl[i*CTRL_W + PRIO_LSB + PRIO_W +: CTRL_W-PRIO_LSB-PRIO_W],
                                       mbx_ctrl[i*CTRL_W + RTR_BIT + 1 +: PRIO_LSB-RTR_BIT-1]};
    end

    logic [N_MBX-1:0] elig;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;

    assign elig = st_q.req & mbx_en & ~mbx_dir;

    mtx_pick_tree #(.N_MBX(N_MBX), .PRIO_W(PRIO_W)) u_pick (
        .elig      (elig),
        .prio_flat (prio_flat),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    logic [CTRL_W-1:0] sel_ctrl;
    assign sel_ctrl = mbx_ctrl[st_q.cur*CTRL_W +: CTRL_W];

    mtx_frame_fields #(.DLC_W(DLC_W), .LEN_MAX(LEN_MAX), .HIGH_THR(4)) u_fields (
        .dlc      (sel_ctrl[DLC_W-1:0]),
        .rtr_in   (sel_ctrl[RTR_BIT]),
        .len      (tx_len),
        .rtr      (tx_rtr),
        .use_high (tx_high_word)
    );

    always_comb begin
        logic [N_MBX-1:0] inflight;
        logic [N_MBX-1:0] cancel;
        logic             finish;
        wr_sel_e          sel;

        st_d     = st_q;
        st_d.start = 1'b0;
        sel      = wr_sel_e'(wr_sel);
        finish   = st_q.busy && tx_done;
        inflight = '0;
        cancel   = '0;

        // mailbox that is (or is becoming) the one on the wire
        if (st_q.busy)      inflight[st_q.cur] = 1'b1;
        else if (win_valid) inflight[win_idx]  = 1'b1;

        // completion drops the request first so a same-cycle set re-raises it
        if (finish) begin
            st_d.req[st_q.cur] = 1'b0;
            st_d.busy          = 1'b0;
        end else if (!st_q.busy && win_valid) begin
            st_d.busy  = 1'b1;
            st_d.start = 1'b1;
            st_d.cur   = win_idx;
        end

        if (wr_en) begin
            unique case (sel)
                WR_REQ_SET: st_d.req = st_d.req | wr_data;
                WR_REQ_CLR: begin
                    cancel   = wr_data & st_q.req & ~inflight;
                    st_d.req = st_d.req & ~cancel;
                    st_d.abt = st_d.abt | cancel;
                end
                WR_ACK_CLR: begin
                    st_d.ack = st_d.ack & ~wr_data;
                    if (|wr_data) st_d.irq = 1'b0;
                end
                WR_ABT_CLR: st_d.abt = st_d.abt & ~wr_data;
                default: ;
            endcase
        end

        // completion events win over same-cycle clears
        if (finish) begin
            st_d.ack[st_q.cur] = 1'b1;
            if (mbx_irq_mask[st_q.cur]) st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_start  = st_q.start;
    assign tx_busy   = st_q.busy;
    assign tx_index  = st_q.cur;
    assign tx_req    = st_q.req;
    assign tx_ack    = st_q.ack;
    assign abort_ack = st_q.abt;
    assign mbx_irq   = st_q.irq;
endmodule

// File: rtl/mtx_prio_arbiter_chk.sv
module mtx_prio_arbiter_chk #(
    parameter int N_MBX = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [1:0]               wr_sel,
    input logic [N_MBX-1:0]         wr_data,
    input logic [N_MBX-1:0]         mbx_en,
    input logic [N_MBX-1:0]         mbx_dir,
    input logic [N_MBX-1:0]         mbx_irq_mask,
    input logic                     tx_start,
    input logic                     tx_busy,
    input logic [$clog2(N_MBX)-1:0] tx_index,
    input logic [3:0]               tx_len,
    input logic                     tx_done,
    input logic [N_MBX-1:0]         tx_req,
    input logic [N_MBX-1:0]         tx_ack,
    input logic                     mbx_irq
);
    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> ((tx_req & $past(wr_data)) == $past(wr_data)));

    assert_start_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (mbx_en[tx_index] && !mbx_dir[tx_index]));

    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> tx_busy);

    assert_index_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !tx_done) |=> (tx_busy && $stable(tx_index)));

    assert_ack_post_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && tx_done) |=> tx_ack[$past(tx_index)]);

    assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && tx_done && !(wr_en && wr_sel == 2'd0)) |=> !tx_req[$past(tx_index)]);

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mbx_irq) |-> $past(tx_busy && tx_done && mbx_irq_mask[tx_index]));

    assert_len_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> (tx_len <= 4'd8));
endmodule

bind mtx_prio_arbiter mtx_prio_arbiter_chk #(.N_MBX(N_MBX)) u_chk (.*);

// File: tb/mtx_prio_arbiter_bench.sv
module mtx_prio_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [N-1:0]  wr_data = '0;
    logic [N-1:0]  mbx_en = '0;
    logic [N-1:0]  mbx_dir = '0;
    logic [N-1:0]  mbx_irq_mask = '0;
    logic [N*16-1:0] mbx_ctrl = '0;
    logic          tx_done = 1'b0;
    logic          tx_start, tx_busy, tx_rtr, tx_high_word, mbx_irq;
    logic [4:0]    tx_index;
    logic [3:0]    tx_len;
    logic [N-1:0]  tx_req, tx_ack, abort_ack;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtx_prio_arbiter u_mtx_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mbx_en(mbx_en), .mbx_dir(mbx_dir), .mbx_irq_mask(mbx_irq_mask),
        .mbx_ctrl(mbx_ctrl), .tx_start(tx_start), .tx_busy(tx_busy),
        .tx_index(tx_index), .tx_len(tx_len), .tx_rtr(tx_rtr),
        .tx_high_word(tx_high_word), .tx_done(tx_done), .tx_req(tx_req),
        .tx_ack(tx_ack), .abort_ack(abort_ack), .mbx_irq(mbx_irq)
    );

    typedef struct packed {
        logic [31:0] req;
        logic [31:0] en;
        logic [31:0] dir;
        logic [1:0]  mode;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 2'd0},
        '{32'h0000_F0F3, 32'hFFFF_FFFF, 32'h0000_0000, 2'd1},
        '{32'h8000_0003, 32'hFFFF_FFFF, 32'h0000_0000, 2'd2},
        '{32'hFFFF_0000, 32'h00FF_FF00, 32'h0F00_0000, 2'd3},
        '{32'hAAAA_5555, 32'hFFFF_FFFF, 32'h0000_0000, 2'd3},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 2'd1}
    };

    function automatic logic [5:0] prio_for(input logic [1:0] mode, input int i);
        case (mode)
            2'd0:    return 6'd5;
            2'd1:    return 6'((i * 13) % 11);
            2'd2:    return 6'(63 - i);
            default: return i[0] ? 6'd20 : 6'd3;
        endcase
    endfunction

    function automatic logic [N*16-1:0] build_ctrl(input logic [1:0] mode);
        logic [N*16-1:0] c = '0;
        for (int i = 0; i < N; i++)
            c[i*16 +: 16] = {2'b00, prio_for(mode, i), 4'b0000, 4'd8};
        return c;
    endfunction

    function automatic int model_pick(input logic [N-1:0] el, input logic [N*16-1:0] c);
        int best = -1;
        int bp = -1;
        for (int i = 0; i < N; i++) begin
            if (el[i] && int'(c[i*16+8 +: 6]) >= bp) begin
                bp = int'(c[i*16+8 +: 6]);
                best = i;
            end
        end
        return best;
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] s, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_busy(output logic ok);
        ok = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (tx_busy) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic finish_frame();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic ok;
        logic [N-1:0] pend;
        logic [N-1:0] el;
        int exp_idx;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tx_req == 0 && tx_ack == 0 && abort_ack == 0, "R1 vectors", tx_req | tx_ack | abort_ack, 0);
        chk(!tx_start && !tx_busy && !mbx_irq, "R1 flags", {tx_start, tx_busy, mbx_irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table-driven order checks (R3, R4, R5, R7)
        mbx_irq_mask = '1;
        for (int v = 0; v < 6; v++) begin
            mbx_en   = VECS[v].en;
            mbx_dir  = VECS[v].dir;
            mbx_ctrl = build_ctrl(VECS[v].mode);
            pend     = VECS[v].req;
            do_write(2'd0, VECS[v].req);
            el = pend & mbx_en & ~mbx_dir;
            while (el != 0) begin
                exp_idx = model_pick(el, mbx_ctrl);
                wait_busy(ok);
                chk(ok && tx_index == 5'(exp_idx), "R4 R5 winner order", tx_index, exp_idx);
                finish_frame();
                chk(tx_ack[exp_idx] && !tx_req[exp_idx], "R7 ack posted", tx_ack, 1 << exp_idx);
                do_write(2'd2, 1 << exp_idx);
                pend[exp_idx] = 1'b0;
                el = pend & mbx_en & ~mbx_dir;
            end
            repeat (4) @(negedge clk);
            chk(!tx_busy && tx_req == pend, "R3 ineligible stay pending", tx_req, pend);
            do_write(2'd1, '1);
            chk(abort_ack == pend && tx_req == 0, "R8 cancel pending", abort_ack, pend);
            do_write(2'd3, '1);
            chk(abort_ack == 0, "R8 abort clear", abort_ack, 0);
            wait_busy(ok);
            do_write(2'd2, '1);
        end

        // R2: zero bits do nothing
        mbx_en = '0; mbx_dir = '0; mbx_ctrl = build_ctrl(2'd2);
        do_write(2'd0, 32'h0000_0008);
        do_write(2'd0, 32'h0);
        chk(tx_req == 32'h8, "R2 zero write no effect", tx_req, 32'h8);
        chk(!tx_busy, "R3 disabled not launched", tx_busy, 0);
        // R8: cancel pending bit 3, bit 5 not pending
        do_write(2'd1, 32'h0000_0028);
        chk(abort_ack == 32'h8 && tx_req == 0, "R8 cancel only pending", abort_ack, 32'h8);
        do_write(2'd3, 32'h8);
        chk(abort_ack == 0, "R8 abort clear bit", abort_ack, 0);

        // R6 no preemption, R8 in-flight ignored, R9 mask
        mbx_en = '1; mbx_irq_mask = 32'h0000_0400;
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h400;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        @(negedge clk);
        chk(tx_start && tx_busy && tx_index == 10, "R6 start pulse", tx_index, 10);
        @(negedge clk);
        chk(!tx_start && tx_busy, "R6 start one cycle", tx_start, 0);
        do_write(2'd0, 32'h1);
        do_write(2'd1, 32'h400);
        chk(tx_busy && tx_index == 10 && tx_req[10], "R6 no preempt", tx_index, 10);
        chk(abort_ack == 0, "R8 in-flight not cancelled", abort_ack, 0);
        finish_frame();
        chk(tx_ack[10] && mbx_irq, "R9 masked completion irq", mbx_irq, 1);
        do_write(2'd2, 32'h400);
        chk(!mbx_irq && !tx_ack[10], "R9 R7 clear", {mbx_irq, tx_ack[10]}, 0);
        wait_busy(ok);
        chk(ok && tx_index == 0, "R6 next after done", tx_index, 0);
        finish_frame();
        chk(tx_ack[0] && !mbx_irq, "R9 unmasked no irq", mbx_irq, 0);
        do_write(2'd2, 32'h1);

        // R10 field decode on mailbox 7
        mbx_ctrl[7*16 +: 16] = 16'h0A1C;
        do_write(2'd0, 32'h80);
        wait_busy(ok);
        chk(tx_len == 8 && tx_high_word && tx_rtr, "R10 cap and rtr", {tx_len, tx_high_word, tx_rtr}, {4'd8, 2'b11});
        finish_frame(); do_write(2'd2, 32'h80);
        mbx_ctrl[7*16 +: 16] = 16'h0A04;
        do_write(2'd0, 32'h80);
        wait_busy(ok);
        chk(tx_len == 4 && !tx_high_word && !tx_rtr, "R10 len4 low only", {tx_len, tx_high_word}, {4'd4, 1'b0});
        finish_frame(); do_write(2'd2, 32'h80);
        mbx_ctrl[7*16 +: 16] = 16'h0A05;
        do_write(2'd0, 32'h80);
        wait_busy(ok);
        chk(tx_len == 5 && tx_high_word, "R10 len5 high word", {tx_len, tx_high_word}, {4'd5, 1'b1});
        finish_frame(); do_write(2'd2, 32'h80);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule